// File: doc/BRIEF.md
# Write-Zero-to-Clear Interrupt Status Register

This block keeps a small set of pending-interrupt flags for a group of peripheral timers. Each flag has its own event source: a one-cycle pulse on that source sets the flag, and the flag stays set until software clears it. Software clears flags with an ordinary bus store to the status word. A 0 in a data bit clears the matching flag. A 1 leaves that flag as it is.

Because a 1 leaves a flag alone, software can drop one flag with a single store of a mask that is all ones except that bit. It needs no read first. This avoids the read, modify and write race, in which an event that lands between the read and the write would be wiped out.

A second word holds one interrupt-enable bit per flag. The interrupt output is raised while any flag is pending with its enable set. Reads of either word are combinational and have no side effects.

Top module: `irqst_w0c_status`

## Requirements
- R1: While reset is asserted, and after it is released, every status flag and every enable bit is 0, both words read back as 0 and `irq_o` is low.
- R2: A 1 on `evt_i[i]` in a cycle sets flag i at that clock edge. With no clearing write to that bit, the flag then stays 1 for any number of cycles.
- R3: A write to the status word (address 0) whose data bit i is 0 clears flag i at that clock edge.
- R4: A write to the status word whose data bit i is 1 leaves flag i unchanged, whether it was 0 or 1.
- R5: Writing 0xFD to the status word clears only flag 1 and keeps every other pending flag.
- R6: When an event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R7: A read of address 0 returns flag i in data bit i (bits 3:0), with bits 7:4 read as 0. Reading has no effect on any flag.
- R8: The enable word (address 1) is written with data bits 3:0 and reads back in bits 3:0. Bits 7:4 read as 0 and ignore writes. Writing it never changes a flag.
- R9: `irq_o` is 1 exactly while some flag i is 1 and enable bit i is 1.
- R10: An event arriving between a software read of the status word and a later write survives that write if its data bit is 1 (direct mask store). A read-AND-write sequence whose mask was built from the stale read value loses it.
- R11: Addresses 2 and 3 read as 0, and writes to them change neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 4 | One-cycle event pulses, one per flag |
| bus_addr_i | input | 2 | Register address: 0 status, 1 enable |
| bus_wr_i | input | 1 | Write strobe for the addressed word |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed word, combinational |
| irq_o | output | 1 | OR of pending flags whose enable is set |

## Verification
Two functions can land on the same flag in the same cycle: an event pulse that sets it, and a status write with a 0 in that bit that clears it. The bench provokes this by driving `evt_i` and a clearing store together in one vector, for one bit and for all four bits at once. It judges the result by reading the status word after the edge and expecting the flag set.

A second collision sits across cycles. An event arrives between a read and the write built from it. The bench runs this twice, once with a stale AND mask and once with the direct 0xFD store. It expects the event lost in the first case and kept in the second.

// File: rtl/irqst_pkg.sv
`timescale 1ns/1ps
package irqst_pkg;
  // Word addresses inside the register window.
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_ENABLE = 1;

  // Clear request for a write-zero-to-clear word.
  function automatic logic zero_clears(input logic wr_hit, input logic data_bit);
    return wr_hit & ~data_bit;
  endfunction
endpackage

// File: rtl/irqst_rst_sync.sv
`timescale 1ns/1ps
module irqst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqst_flag_cell.sv
`timescale 1ns/1ps
module irqst_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_ce;

  // Set has priority over clear: an event coinciding with a clearing write wins.
  always_comb begin
    flag_ce = set_i | clr_i;
    flag_d  = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqst_flag_bank.sv
`timescale 1ns/1ps
module irqst_flag_bank #(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 wr_hit_i,
  input  logic [NUM_FLAGS-1:0] wdata_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  import irqst_pkg::*;

  logic [NUM_FLAGS-1:0] clr_req;

  always_comb begin
    for (int b = 0; b < NUM_FLAGS; b++) begin
      clr_req[b] = zero_clears(wr_hit_i, wdata_i[b]);
    end
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    irqst_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_i[g]),
      .clr_i  (clr_req[g]),
      .flag_o (flags_o[g])
    );
  end
endmodule

// File: rtl/irqst_enable_reg.sv
`timescale 1ns/1ps
module irqst_enable_reg #(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [NUM_FLAGS-1:0] wdata_i,
  output logic [NUM_FLAGS-1:0] en_o
);
  logic [NUM_FLAGS-1:0] en_q;
  logic [NUM_FLAGS-1:0] en_d;

  always_comb begin
    en_d = load_i ? wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (load_i) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/irqst_read_mux.sv
`timescale 1ns/1ps
module irqst_read_mux #(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                 sel_status_i,
  input  logic                 sel_enable_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  always_comb begin
    rdata_o = '0;
    if (sel_status_i) begin
      rdata_o = DATA_W'(flags_i);
    end else if (sel_enable_i) begin
      rdata_o = DATA_W'(en_i);
    end
  end

  always_comb begin
    irq_o = |(flags_i & en_i);
  end
endmodule

// File: rtl/irqst_w0c_status.sv
`timescale 1ns/1ps
module irqst_w0c_status #(
  parameter int NUM_FLAGS  = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_o
);
  import irqst_pkg::*;

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_ENABLE);

  logic                 rst_core_n;
  logic                 sel_status;
  logic                 sel_enable;
  logic                 stat_wr;
  logic                 en_wr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] en_q;

  always_comb begin
    sel_status = (bus_addr_i == A_STAT);
    sel_enable = (bus_addr_i == A_EN);
    stat_wr    = bus_wr_i & sel_status;
    en_wr      = bus_wr_i & sel_enable;
  end

  irqst_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  irqst_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .evt_i    (evt_i),
    .wr_hit_i (stat_wr),
    .wdata_i  (bus_wdata_i[NUM_FLAGS-1:0]),
    .flags_o  (flag_q)
  );

  irqst_enable_reg #(.NUM_FLAGS(NUM_FLAGS)) u_en (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_i  (en_wr),
    .wdata_i (bus_wdata_i[NUM_FLAGS-1:0]),
    .en_o    (en_q)
  );

  irqst_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd (
    .sel_status_i (sel_status),
    .sel_enable_i (sel_enable),
    .flags_i      (flag_q),
    .en_i         (en_q),
    .rdata_o      (bus_rdata_o),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/irqst_w0c_checker.sv
`timescale 1ns/1ps
module irqst_w0c_checker #(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic [NUM_FLAGS-1:0] evt_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic                 bus_wr_i,
  input logic [DATA_W-1:0]    bus_wdata_i,
  input logic [DATA_W-1:0]    bus_rdata_o,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] flag_q,
  input logic [NUM_FLAGS-1:0] en_q
);
  logic st_wr;
  logic en_wr;
  logic unmapped;

  assign st_wr    = bus_wr_i && (bus_addr_i == ADDR_W'(0));
  assign en_wr    = bus_wr_i && (bus_addr_i == ADDR_W'(1));
  assign unmapped = (bus_addr_i != ADDR_W'(0)) && (bus_addr_i != ADDR_W'(1));

  // R2 / R6: any pulsed event is set one edge later, even under a clearing write.
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R2: a flag only rises because of its own event.
  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0));

  // R4 / R8 / R11: without a status write no flag is lost.
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !st_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R3 / R4: a status write keeps exactly the 1-bits and any new events.
  assert_w0c_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    st_wr |=> (flag_q == (($past(flag_q) & $past(bus_wdata_i[NUM_FLAGS-1:0])) | $past(evt_i))));

  // R8: the enable word takes the written low bits.
  assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    en_wr |=> (en_q == $past(bus_wdata_i[NUM_FLAGS-1:0])));

  // R9: the interrupt needs a pending and enabled flag.
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_o |-> ((flag_q & en_q) != '0));

  // R11: unmapped addresses read zero.
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    unmapped |-> (bus_rdata_o == '0));

  // R7: upper bits of the status word read zero.
  assert_status_upper_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr_i == ADDR_W'(0)) |-> ((bus_rdata_o >> NUM_FLAGS) == '0));
endmodule

bind irqst_w0c_status irqst_w0c_checker #(
  .NUM_FLAGS (NUM_FLAGS),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .evt_i       (evt_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .flag_q      (flag_q),
  .en_q        (en_q)
);

// File: tb/sim_irqst_w0c_status.sv
`timescale 1ns/1ps
module sim_irqst_w0c_status;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 14;

  logic       clk;
  logic       rst_n;
  logic [3:0] evt;
  logic [1:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irqst_w0c_status u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Entry: {evt[3:0], wr, addr[1:0], wdata[7:0], expected flags[3:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {4'b0001, 1'b0, 2'd0, 8'h00, 4'b0001},  // R2 set
    {4'b0100, 1'b0, 2'd0, 8'h00, 4'b0101},  // R2 second flag
    {4'b0000, 1'b0, 2'd0, 8'h00, 4'b0101},  // R2 hold
    {4'b0000, 1'b1, 2'd0, 8'hFF, 4'b0101},  // R4 all ones
    {4'b1010, 1'b0, 2'd0, 8'h00, 4'b1111},  // R2 two events
    {4'b0000, 1'b1, 2'd0, 8'hFD, 4'b1101},  // R5 mask 0xFD
    {4'b1000, 1'b1, 2'd0, 8'hF7, 4'b1101},  // R6 collision bit 3
    {4'b0000, 1'b1, 2'd0, 8'hFE, 4'b1100},  // R3 clear bit 0
    {4'b0000, 1'b1, 2'd2, 8'h00, 4'b1100},  // R11 unmapped write
    {4'b0000, 1'b1, 2'd1, 8'h00, 4'b1100},  // R8 enable write
    {4'b0000, 1'b1, 2'd0, 8'hF0, 4'b0000},  // R3 clear all low bits
    {4'b1111, 1'b1, 2'd0, 8'h00, 4'b1111},  // R6 collision all bits
    {4'b0000, 1'b1, 2'd0, 8'h0F, 4'b1111},  // R4 upper zeros ignored
    {4'b0000, 1'b1, 2'd0, 8'h00, 4'b0000}   // R3 clear everything
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt = '0; wr = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  // Drive one cycle of stimulus; returns 1 time unit after the edge with inputs idle.
  task automatic cycle(input logic [3:0] e, input logic w, input logic [1:0] a, input logic [7:0] d);
    evt = e; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; wr = 1'b0;
    #1;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] snap;
    idle();
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rd(2'd0, v); check("R1 status in reset", v, 8'h00);
    check("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rd(2'd0, v); check("R1 status after reset", v, 8'h00);
    rd(2'd1, v); check("R1 enable after reset", v, 8'h00);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(2'd2, v); check("R11 addr 2 reads 0", v, 8'h00);
    rd(2'd3, v); check("R11 addr 3 reads 0", v, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][18:15], VEC[i][14], VEC[i][13:12], VEC[i][11:4]);
      rd(2'd0, v);
      check($sformatf("R2-R6 vector %0d", i), v, {4'h0, VEC[i][3:0]});
    end

    // R7: read-only access has no side effect, upper bits zero
    cycle(4'b1001, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); check("R7 first read", v, 8'h09);
    @(posedge clk); #1;
    @(posedge clk); #1;
    rd(2'd0, v); check("R7 repeated read", v, 8'h09);

    // R8: enable word read/write with upper bits ignored
    cycle(4'b0000, 1'b1, 2'd1, 8'hFF);
    rd(2'd1, v); check("R8 enable upper ignored", v, 8'h0F);
    rd(2'd0, v); check("R8 flags untouched", v, 8'h09);
    check("R9 irq with enables", {7'd0, irq}, 8'h01);
    cycle(4'b0000, 1'b1, 2'd1, 8'h06);
    rd(2'd1, v); check("R8 enable value", v, 8'h06);
    check("R9 irq masked", {7'd0, irq}, 8'h00);
    cycle(4'b0100, 1'b0, 2'd0, 8'h00);
    check("R9 irq enabled flag", {7'd0, irq}, 8'h01);
    cycle(4'b0000, 1'b1, 2'd3, 8'h00);
    rd(2'd1, v); check("R11 enable untouched", v, 8'h06);
    rd(2'd0, v); check("R11 flags untouched", v, 8'h0D);
    cycle(4'b0000, 1'b1, 2'd0, 8'hFB);
    check("R9 irq drops on clear", {7'd0, irq}, 8'h00);

    // R10: read-AND-write loses an event arriving mid-sequence
    cycle(4'b0000, 1'b1, 2'd0, 8'h00);
    cycle(4'b0010, 1'b0, 2'd0, 8'h00);
    rd(2'd0, snap); check("R10 snapshot", snap, 8'h02);
    cycle(4'b1000, 1'b0, 2'd0, 8'h00);
    cycle(4'b0000, 1'b1, 2'd0, snap & 8'hFD);
    rd(2'd0, v); check("R10 read-AND-write loses event", v, 8'h00);
    // R10: direct mask store keeps it
    cycle(4'b0010, 1'b0, 2'd0, 8'h00);
    rd(2'd0, snap); check("R10 snapshot again", snap, 8'h02);
    cycle(4'b1000, 1'b0, 2'd0, 8'h00);
    cycle(4'b0000, 1'b1, 2'd0, 8'hFD);
    rd(2'd0, v); check("R10 direct mask keeps event", v, 8'h08);

    // R1: reset mid-run clears flags and enables
    cycle(4'b0000, 1'b1, 2'd1, 8'h0F);
    rst_n = 1'b0;
    #1;
    rd(2'd0, v); check("R1 mid-run status cleared", v, 8'h00);
    rd(2'd1, v); check("R1 mid-run enable cleared", v, 8'h00);
    check("R1 mid-run irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule